// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block watches a running calendar, held in BCD, and raises an alarm interrupt when the time reaches a programmed value. It stores six alarm fields: second, minute, hour, day of month, month and a three-digit year. Each field is truncated to its legal BCD width when it is written. A control register picks which fields take part in the comparison and holds a master alarm switch.

The calendar logic outside the block advances the time. Each time it does so, it pulses a one-cycle strobe with the new values already on the current-time inputs. On that strobe, if the master switch is on, the block compares every selected field with its current value. If any one of the selected fields is equal, a sticky pending bit is set. The alarm interrupt output follows that bit as a level. Software clears it by writing a one to the pending bit's position in the status register.

Register access is one write port and one combinational read port, decoded by a 3-bit address:

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Status |
| 2 | Second |
| 3 | Minute |
| 4 | Hour |
| 5 | Day of month |
| 6 | Month |
| 7 | Year |

Top module: `calm_top`

## Requirements
- R1: After reset, all eight addresses read 0 and `alarm_irq` is low.
- R2: The control register is at address 0 and keeps write bits [6:0]; reads return them with the upper bits zero.
  - Bits 0 to 5 enable the comparison of second, minute, hour, day, month and year, in that order.
  - Bit 6 is the master alarm enable.
- R3: The alarm field registers keep only these write bits, and reads return them zero-extended:
  - second (address 2), bits [6:0];
  - minute (address 3), bits [6:0];
  - hour (address 4), bits [5:0];
  - day (address 5), bits [5:0];
  - month (address 6), bits [4:0];
  - year (address 7), bits [11:0].
- R4: The year is compared over all 12 bits: tens and units in [7:0], hundreds in [11:8]. A year that differs only in the hundreds digit does not match.
- R5: When `sec_tick` is high, the master enable is set, and at least one enabled field equals its current input, the alarm fires. This is an OR over the enabled fields.
- R6: Nothing fires while the master enable is clear, and nothing fires in a cycle without `sec_tick`, even if fields match.
- R7: With the master enable set but no field enabled, the alarm never fires.
- R8: The status register (address 1) shows the pending flag in bit 1. `alarm_irq` equals that flag. Once set, the flag stays set through later ticks, whether they match or not.
- R9: Writing a value with bit 1 set to address 1 clears the pending flag. Writing a value with bit 1 clear has no effect. A status write leaves the alarm fields unchanged.
- R10: If a firing and a clear fall in the same cycle, the flag ends up set.
- R11: A firing is seen on `alarm_irq` in the cycle after the `sec_tick` cycle, not in the tick cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| cur_sec | input | 8 | Current second, BCD |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| cur_year | input | 12 | Current year, three BCD digits |
| sec_tick | input | 1 | One-cycle strobe after each calendar advance |
| alarm_irq | output | 1 | Sticky alarm interrupt level |

## Verification
The assertions assume that `sec_tick` lasts one cycle per calendar advance. They also assume that the current-time inputs are stable and already advanced in that cycle, so that "fire" means one compare on one strobe.

The stimulus keeps to these assumptions:
- It changes the time inputs only at the falling edge.
- It pulses the strobe for exactly one cycle.
- It moves the clear write to the same edge as a strobe only in the collision test.

The current values are valid BCD except where a test wants a mismatch. That case includes a year that differs only in its hundreds digit.

// File: rtl/calm_pkg.sv
package calm_pkg;
  localparam int NUM_FLD    = 6;
  localparam int FLD_W      = 12;
  localparam int CTRL_W     = 7;
  localparam int GLOBAL_BIT = 6;
  localparam int PEND_BIT   = 1;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_SEC  = 3'd2,
    A_MIN  = 3'd3,
    A_HOUR = 3'd4,
    A_DAY  = 3'd5,
    A_MON  = 3'd6,
    A_YEAR = 3'd7
  } calm_addr_e;

  // legal BCD bit-width of each alarm field, index 0 = second .. 5 = year
  function automatic logic [FLD_W-1:0] fld_mask(input int idx);
    case (idx)
      0, 1:    return 12'h07F;
      2, 3:    return 12'h03F;
      4:       return 12'h01F;
      default: return 12'hFFF;
    endcase
  endfunction

  // full-width equality: stray high bits in the current value block a match
  function automatic logic fld_equal(input logic [FLD_W-1:0] alarm,
                                     input logic [FLD_W-1:0] now);
    return alarm == now;
  endfunction
endpackage

// File: rtl/calm_field_regs.sv
module calm_field_regs
  import calm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [FLD_W-1:0]  fld_q [NUM_FLD]
);
  logic [NUM_FLD-1:0] fld_we;

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_SEC) + g);
    assign fld_we[g] = wr_en && (wr_addr == MY_ADDR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en && wr_addr == A_CTRL) begin
      ctrl_q <= wr_data[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_FLD; i++) begin
      if (!rst_n) begin
        fld_q[i] <= '0;
      end else if (fld_we[i]) begin
        fld_q[i] <= wr_data[FLD_W-1:0] & fld_mask(i);
      end
    end
  end
endmodule

// File: rtl/calm_match.sv
module calm_match
  import calm_pkg::*;
(
  input  logic [FLD_W-1:0]   fld_q [NUM_FLD],
  input  logic [FLD_W-1:0]   cur   [NUM_FLD],
  input  logic [NUM_FLD-1:0] fld_en,
  output logic [NUM_FLD-1:0] hit_vec,
  output logic               any_hit
);
  for (genvar g = 0; g < NUM_FLD; g++) begin : g_cmp
    assign hit_vec[g] = fld_en[g] && fld_equal(fld_q[g], cur[g]);
  end

  // any single enabled field suffices
  assign any_hit = |hit_vec;
endmodule

// File: rtl/calm_status.sv
module calm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic eval,
  input  logic hit,
  input  logic clr,
  output logic pending
);
  logic fire;
  assign fire = eval && hit;

  always_ff @(posedge clk) begin
    if (!rst_n)    pending <= 1'b0;
    else if (fire) pending <= 1'b1;   // a new firing outranks a clear
    else if (clr)  pending <= 1'b0;
  end

  a_r5_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pending);
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire) |=> !pending);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> pending);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !fire) |=> !pending);
endmodule

// File: rtl/calm_top.sv
module calm_top
  import calm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_day,
  input  logic [7:0]        cur_mon,
  input  logic [11:0]       cur_year,
  input  logic              sec_tick,
  output logic              alarm_irq
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic [FLD_W-1:0]   fld_q [NUM_FLD];
  logic [FLD_W-1:0]   cur   [NUM_FLD];
  logic [NUM_FLD-1:0] hit_vec;
  logic               any_hit;
  logic               eval;
  logic               clr;
  logic               pending;

  always_comb begin
    cur[0] = FLD_W'(cur_sec);
    cur[1] = FLD_W'(cur_min);
    cur[2] = FLD_W'(cur_hour);
    cur[3] = FLD_W'(cur_day);
    cur[4] = FLD_W'(cur_mon);
    cur[5] = cur_year;
  end

  calm_field_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .fld_q   (fld_q)
  );

  calm_match u_match (
    .fld_q   (fld_q),
    .cur     (cur),
    .fld_en  (ctrl_q[NUM_FLD-1:0]),
    .hit_vec (hit_vec),
    .any_hit (any_hit)
  );

  assign eval = sec_tick && ctrl_q[GLOBAL_BIT];
  assign clr  = wr_en && (wr_addr == A_STAT) && wr_data[PEND_BIT];

  calm_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .eval    (eval),
    .hit     (any_hit),
    .clr     (clr),
    .pending (pending)
  );

  assign alarm_irq = pending;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = DATA_W'(ctrl_q);
      A_STAT:  rd_data[PEND_BIT] = pending;
      default: rd_data = DATA_W'(fld_q[int'(rd_addr) - int'(A_SEC)]);
    endcase
  end

  a_r6_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !ctrl_q[GLOBAL_BIT] && !alarm_irq) |=> !alarm_irq);
  a_r11_no_tick_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !alarm_irq) |=> !alarm_irq);
endmodule

// File: tb/calm_top_tb.sv
module calm_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [7:0]  cur_sec = '0, cur_min = '0, cur_hour = '0, cur_day = 8'h01, cur_mon = 8'h01;
  logic [11:0] cur_year = '0;
  logic        sec_tick = 1'b0;
  logic        alarm_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  calm_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_day(cur_day), .cur_mon(cur_mon), .cur_year(cur_year),
    .sec_tick(sec_tick), .alarm_irq(alarm_irq)
  );

  always #2 clk = ~clk;

  // {ctrl[6:0], sec, min, hour, day, mon, year[11:0], expect}
  localparam int NV = 13;
  localparam logic [59:0] VEC [NV] = '{
    {7'h41, 8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000, 1'b1}, // R5 second
    {7'h41, 8'h31, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000, 1'b0}, // R5 second off by one
    {7'h42, 8'h00, 8'h45, 8'h00, 8'h01, 8'h01, 12'h000, 1'b1}, // R5 minute
    {7'h44, 8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 12'h000, 1'b1}, // R5 hour
    {7'h48, 8'h00, 8'h00, 8'h00, 8'h15, 8'h01, 12'h000, 1'b1}, // R5 day
    {7'h50, 8'h00, 8'h00, 8'h00, 8'h01, 8'h07, 12'h000, 1'b1}, // R5 month
    {7'h60, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h124, 1'b1}, // R4 year
    {7'h60, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h024, 1'b0}, // R4 hundreds differ
    {7'h7F, 8'h00, 8'h45, 8'h00, 8'h01, 8'h01, 12'h000, 1'b1}, // R5 OR: one of six
    {7'h7F, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000, 1'b0}, // R5 none equal
    {7'h01, 8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 12'h000, 1'b0}, // R6 master off
    {7'h40, 8'h30, 8'h45, 8'h12, 8'h15, 8'h07, 12'h124, 1'b0}, // R7 no field enabled
    {7'h43, 8'h30, 8'h44, 8'h00, 8'h01, 8'h01, 12'h000, 1'b1}  // R5 sec yes, min no
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic set_cur(input logic [59:0] v);
    cur_sec = v[52:45]; cur_min = v[44:37]; cur_hour = v[36:29];
    cur_day = v[28:21]; cur_mon = v[20:13]; cur_year = v[12:1];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 3'(a), 16'h0);
    chk("R1 reset irq", {15'h0, alarm_irq}, 16'h0);

    // R2 / R3 write masks
    wr(3'd0, 16'hFFFF); rd_chk("R2 ctrl mask", 3'd0, 16'h007F);
    wr(3'd2, 16'hFFFF); rd_chk("R3 sec mask",  3'd2, 16'h007F);
    wr(3'd3, 16'hFFFF); rd_chk("R3 min mask",  3'd3, 16'h007F);
    wr(3'd4, 16'hFFFF); rd_chk("R3 hour mask", 3'd4, 16'h003F);
    wr(3'd5, 16'hFFFF); rd_chk("R3 day mask",  3'd5, 16'h003F);
    wr(3'd6, 16'hFFFF); rd_chk("R3 mon mask",  3'd6, 16'h001F);
    wr(3'd7, 16'hFFFF); rd_chk("R3 year mask", 3'd7, 16'h0FFF);
    wr(3'd0, 16'h0000);

    // alarm: 1xx year 124, month 07, day 15, 12:45:30
    wr(3'd2, 16'h0030); wr(3'd3, 16'h0045); wr(3'd4, 16'h0012);
    wr(3'd5, 16'h0015); wr(3'd6, 16'h0007); wr(3'd7, 16'h0124);
    rd_chk("R3 year readback", 3'd7, 16'h0124);

    // table walk: R4 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, {9'h0, VEC[i][59:53]});
      wr(3'd1, 16'h0002);
      set_cur(VEC[i]);
      @(negedge clk);
      sec_tick = 1'b1;
      #1;
      chk($sformatf("R11 not in tick cycle vec%0d", i), {15'h0, alarm_irq}, 16'h0);
      @(negedge clk);
      sec_tick = 1'b0;
      chk($sformatf("R5 irq vec%0d", i), {15'h0, alarm_irq}, {15'h0, VEC[i][0]});
      rd_chk($sformatf("R8 status vec%0d", i), 3'd1, {14'h0, VEC[i][0], 1'b0});
    end

    // R6 no tick: matching values held without strobe
    wr(3'd0, 16'h0041);
    wr(3'd1, 16'h0002);
    cur_sec = 8'h30; cur_min = 8'h00; cur_hour = 8'h00;
    cur_day = 8'h01; cur_mon = 8'h01; cur_year = 12'h000;
    repeat (5) @(negedge clk);
    chk("R6 no tick no fire", {15'h0, alarm_irq}, 16'h0);

    // R8 sticky across a non-matching tick
    tick();
    chk("R8 fired", {15'h0, alarm_irq}, 16'h1);
    cur_sec = 8'h59;
    tick();
    chk("R8 sticky after miss", {15'h0, alarm_irq}, 16'h1);

    // R9 writes without bit 1 do nothing; bit 1 clears
    wr(3'd1, 16'h0001);
    chk("R9 bit0 write ignored", {15'h0, alarm_irq}, 16'h1);
    wr(3'd1, 16'hFFFD);
    chk("R9 other bits ignored", {15'h0, alarm_irq}, 16'h1);
    wr(3'd1, 16'h0002);
    chk("R9 clear", {15'h0, alarm_irq}, 16'h0);
    rd_chk("R9 status cleared", 3'd1, 16'h0);
    rd_chk("R9 sec field intact", 3'd2, 16'h0030);

    // R10 fire and clear in the same cycle
    cur_sec = 8'h30;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h0002; sec_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sec_tick = 1'b0;
    chk("R10 fire beats clear", {15'h0, alarm_irq}, 16'h1);

    // R1 reset again clears pending
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset clears irq", {15'h0, alarm_irq}, 16'h0);
    rd_chk("R1 reset clears year", 3'd7, 16'h0);

    finish_run();
  end
endmodule